// File: doc/BRIEF.md
# AES Round Key Expansion Unit

This unit turns a 128-bit or 256-bit AES cipher key into the complete round key schedule. It keeps the schedule in a small internal register array, which the encipher and decipher datapaths both read by round number. A single-cycle `init_i` pulse starts the expansion. The unit captures the key and the key-length select on that pulse, then produces one 128-bit round key per clock. It makes 11 round keys for a 128-bit key and 15 round keys for a 256-bit key. The 192-bit key length is not supported.

The unit contains no substitution boxes. It puts the last word of the previous round key on `sbox_word_o`, and the encipher datapath's four byte substitution tables return the substituted word on `sbox_sub_i` within the same cycle. `sbox_use_o` tells the surrounding logic to steer those tables to the unit. Because the tables are shared, block processing may start only when `ready_o` is high. `ready_o` stays low from the init pulse until the last round key has been written.

Top module: `aes_key_expander`

## Requirements
- R1: After reset, `ready_o` and `sbox_use_o` are both low.
- R2: With `key_len_i`=0, the key is taken from `key_i[255:128]`, with byte 0 in bits 255:248. Round keys 0 to 10 follow the standard AES-128 expansion, and round key 0 is the key itself. Each round key after the first applies byte rotation, substitution and the round constant to the last word of the previous round key. The round constant starts at 0x01 and doubles in GF(2^8) modulo 0x11b, once per use.
- R3: With `key_len_i`=1, round key 0 is `key_i[255:128]` and round key 1 is `key_i[127:0]`. Round keys 2 to 14 follow the standard AES-256 expansion. Even-numbered round keys apply rotation, substitution and the round constant. Odd-numbered round keys apply substitution only.
- R4: In 128-bit mode, the value of `key_i[127:0]` has no effect on any round key.
- R5: `sbox_use_o` is high on every cycle of an expansion and low when idle. During expansion, `sbox_word_o` carries the word to substitute, and `sbox_sub_i` is consumed in the same cycle.
- R6: `ready_o` is low during expansion. It goes high on exactly the 11th rising edge after the edge that samples `init_i` in 128-bit mode, and on the 15th in 256-bit mode.
- R7: Changes on `key_i` or `key_len_i` after the init pulse do not alter the schedule being generated.
- R8: `rd_key_o` returns, combinationally, the stored round key at index `rd_idx_i`. Indices 0 to 14 are valid.
- R9: An init pulse during an expansion restarts it with the newly sampled key and length. The full expansion time then runs again from that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_i | input | 1 | Start expansion; samples key and length |
| key_len_i | input | 1 | 0 selects a 128-bit key, 1 selects a 256-bit key |
| key_i | input | 256 | Cipher key, left aligned |
| ready_o | output | 1 | Schedule complete and valid |
| sbox_use_o | output | 1 | Unit owns the shared substitution tables |
| sbox_word_o | output | 32 | Word to substitute |
| sbox_sub_i | input | 32 | Substituted word from shared tables |
| rd_idx_i | input | 4 | Round key index to read |
| rd_key_o | output | 128 | Round key at `rd_idx_i` |

## Verification
The bench uses the default parameters: 32-bit words, 128-bit round keys and a 15-entry store. This reaches both key lengths and the highest index, 14. The bench models the shared substitution tables with a computed GF(2^8) inverse followed by the affine map, and builds reference schedules with a word-by-word expansion model. Both published standard examples are checked against fixed constants for selected round keys, including the final ones. Those final keys depend on the full round constant sequence, through 0x1b and 0x36. Restarts and mid-run input changes are driven at chosen cycles inside an expansion.

// File: rtl/aes_kexp_pkg.sv
package aes_kexp_pkg;
  localparam int WORD_W = 32;
  localparam int RK_W   = 128;
  localparam int KEY_W  = 256;
  localparam int IDX_W  = 4;
  localparam int RK_MAX = 15;

  // multiply by x in GF(2^8), modulus 0x11b
  function automatic logic [7:0] gf_dbl(input logic [7:0] v);
    return {v[6:0], 1'b0} ^ (v[7] ? 8'h1b : 8'h00);
  endfunction
endpackage

// File: rtl/aes_kexp_rcon.sv
module aes_kexp_rcon (
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic       advance,
  output logic [7:0] rcon_o
);
  import aes_kexp_pkg::*;

  logic [7:0] rcon_q;

  always_ff @(posedge clk) begin
    if (rst || restart) rcon_q <= 8'h01;
    else if (advance)   rcon_q <= gf_dbl(rcon_q);
  end

  assign rcon_o = rcon_q;

  // R2
  rcon_restart_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> rcon_q == 8'h01);

  // R2
  rcon_moves_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && !restart) |=> rcon_q != $past(rcon_q));
endmodule

// File: rtl/aes_kexp_next.sv
module aes_kexp_next #(
  parameter int WORD_W = aes_kexp_pkg::WORD_W,
  parameter int RK_W   = aes_kexp_pkg::RK_W
) (
  input  logic [RK_W-1:0]   prev1_i,
  input  logic [RK_W-1:0]   prev2_i,
  input  logic              use_older_i,
  input  logic              apply_rot_i,
  input  logic [7:0]        rcon_i,
  input  logic [WORD_W-1:0] sub_i,
  output logic [RK_W-1:0]   next_o
);
  localparam int NW = RK_W / WORD_W;

  logic [WORD_W-1:0] temp;
  logic [RK_W-1:0]   base;
  logic [WORD_W-1:0] w [NW];

  // rotation after substitution equals substitution after rotation
  assign temp = apply_rot_i
              ? ({sub_i[WORD_W-9:0], sub_i[WORD_W-1:WORD_W-8]} ^ {rcon_i, {(WORD_W-8){1'b0}}})
              : sub_i;
  assign base = use_older_i ? prev2_i : prev1_i;

  for (genvar j = 0; j < NW; j++) begin : g_word
    localparam int HI = RK_W - 1 - j*WORD_W;
    if (j == 0) begin : g_first
      assign w[j] = base[HI -: WORD_W] ^ temp;
    end else begin : g_chain
      assign w[j] = base[HI -: WORD_W] ^ w[j-1];
    end
    assign next_o[HI -: WORD_W] = w[j];
  end
endmodule

// File: rtl/aes_kexp_store.sv
module aes_kexp_store #(
  parameter int RK_W  = aes_kexp_pkg::RK_W,
  parameter int IDX_W = aes_kexp_pkg::IDX_W,
  parameter int DEPTH = aes_kexp_pkg::RK_MAX
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [RK_W-1:0]  wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [RK_W-1:0]  rd_data
);
  logic [RK_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = (rd_idx < IDX_W'(DEPTH)) ? mem[rd_idx] : '0;

  // R8
  wr_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> wr_idx < IDX_W'(DEPTH));
endmodule

// File: rtl/aes_key_expander.sv
module aes_key_expander #(
  parameter int WORD_W = aes_kexp_pkg::WORD_W,
  parameter int RK_W   = aes_kexp_pkg::RK_W,
  parameter int KEY_W  = aes_kexp_pkg::KEY_W,
  parameter int IDX_W  = aes_kexp_pkg::IDX_W,
  parameter int RK_MAX = aes_kexp_pkg::RK_MAX
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_i,
  input  logic              key_len_i,
  input  logic [KEY_W-1:0]  key_i,
  output logic              ready_o,
  output logic              sbox_use_o,
  output logic [WORD_W-1:0] sbox_word_o,
  input  logic [WORD_W-1:0] sbox_sub_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [RK_W-1:0]   rd_key_o
);
  localparam logic [IDX_W-1:0] LAST_128 = IDX_W'(10);
  localparam logic [IDX_W-1:0] LAST_256 = IDX_W'(RK_MAX - 1);

  logic             busy_q, ready_q, len_q;
  logic [KEY_W-1:0] key_q;
  logic [IDX_W-1:0] round_q, last_idx;
  logic [RK_W-1:0]  prev1_q, prev2_q, gen_rk, new_rk;
  logic             from_key, apply_rot, wr_en;
  logic [7:0]       rcon;

  assign last_idx  = len_q ? LAST_256 : LAST_128;
  assign from_key  = (round_q == '0) || (len_q && round_q == IDX_W'(1));
  assign apply_rot = !len_q || !round_q[0];
  assign wr_en     = busy_q && !init_i;
  assign new_rk    = (round_q == '0) ? key_q[KEY_W-1 -: RK_W]
                   : from_key        ? key_q[RK_W-1:0]
                   : gen_rk;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      ready_q <= 1'b0;
      round_q <= '0;
    end else if (init_i) begin
      busy_q  <= 1'b1;
      ready_q <= 1'b0;
      round_q <= '0;
    end else if (busy_q) begin
      if (round_q == last_idx) begin
        busy_q  <= 1'b0;
        ready_q <= 1'b1;
      end else begin
        round_q <= round_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (init_i) begin
      key_q <= key_i;
      len_q <= key_len_i;
    end else if (busy_q) begin
      prev2_q <= prev1_q;
      prev1_q <= new_rk;
    end
  end

  aes_kexp_rcon u_rcon (
    .clk     (clk),
    .rst     (rst),
    .restart (init_i),
    .advance (wr_en && !from_key && apply_rot),
    .rcon_o  (rcon)
  );

  aes_kexp_next #(.WORD_W(WORD_W), .RK_W(RK_W)) u_next (
    .prev1_i     (prev1_q),
    .prev2_i     (prev2_q),
    .use_older_i (len_q),
    .apply_rot_i (apply_rot),
    .rcon_i      (rcon),
    .sub_i       (sbox_sub_i),
    .next_o      (gen_rk)
  );

  aes_kexp_store #(.RK_W(RK_W), .IDX_W(IDX_W), .DEPTH(RK_MAX)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (round_q),
    .wr_data (new_rk),
    .rd_idx  (rd_idx_i),
    .rd_data (rd_key_o)
  );

  assign ready_o     = ready_q;
  assign sbox_use_o  = busy_q;
  assign sbox_word_o = prev1_q[WORD_W-1:0];

  // R6
  ready_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> !ready_q);

  // R6
  ready_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_q) |-> ($past(wr_en) && $past(round_q) == $past(last_idx)));

  // R7
  sampled_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !init_i) |=> ($stable(len_q) && $stable(key_q)));
endmodule

// File: tb/aes_key_expander_tb.sv
module aes_key_expander_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         init_i = 1'b0;
  logic         key_len_i = 1'b0;
  logic [255:0] key_i = '0;
  logic         ready_o, sbox_use_o;
  logic [31:0]  sbox_word_o, sbox_sub_i;
  logic [3:0]   rd_idx_i = '0;
  logic [127:0] rd_key_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] ref_w [60];

  localparam logic [255:0] K128 = {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0};
  localparam logic [255:0] K256 =
    256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4;

  always #2.5 clk = ~clk;

  aes_key_expander u_dut (
    .clk(clk), .rst(rst), .init_i(init_i), .key_len_i(key_len_i), .key_i(key_i),
    .ready_o(ready_o), .sbox_use_o(sbox_use_o), .sbox_word_o(sbox_word_o),
    .sbox_sub_i(sbox_sub_i), .rd_idx_i(rd_idx_i), .rd_key_o(rd_key_o)
  );

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 8'h00;
    for (int i = 0; i < 8; i++) begin
      if (b[0]) p = p ^ a;
      a = {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
      b = b >> 1;
    end
    return p;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] x);
    logic [7:0] inv = 8'h00;
    if (x != 8'h00)
      for (int y = 1; y < 256; y++)
        if (gmul(x, 8'(y)) == 8'h01) inv = 8'(y);
    return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^
           {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [31:0] subw(input logic [31:0] w);
    return {sbox(w[31:24]), sbox(w[23:16]), sbox(w[15:8]), sbox(w[7:0])};
  endfunction

  // shared substitution tables of the encipher datapath
  always_comb sbox_sub_i = subw(sbox_word_o);

  task automatic build_ref(input logic [255:0] key, input logic is256);
    int nk = is256 ? 8 : 4;
    int total = is256 ? 60 : 44;
    logic [7:0] rc = 8'h01;
    logic [31:0] t;
    for (int i = 0; i < nk; i++) ref_w[i] = key[255 - 32*i -: 32];
    for (int i = nk; i < total; i++) begin
      t = ref_w[i-1];
      if (i % nk == 0) begin
        t = subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
        rc = gmul(rc, 8'h02);
      end else if (nk == 8 && i % nk == 4) begin
        t = subw(t);
      end
      ref_w[i] = ref_w[i-nk] ^ t;
    end
  endtask

  function automatic logic [127:0] ref_rk(input int r);
    return {ref_w[4*r], ref_w[4*r+1], ref_w[4*r+2], ref_w[4*r+3]};
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_rk(input int r, output logic [127:0] v);
    rd_idx_i = 4'(r);
    #0.5;
    v = rd_key_o;
  endtask

  task automatic start(input logic [255:0] key, input logic len);
    @(negedge clk);
    key_i = key; key_len_i = len; init_i = 1'b1;
    @(negedge clk);
    init_i = 1'b0;
  endtask

  // waits out an expansion, checking ready timing (R6) and port ownership (R5)
  task automatic wait_done(input int n, input string tag);
    chk({tag, " R5 use"}, 128'(sbox_use_o), 128'd1);
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      chk({tag, " R6 ready"}, 128'(ready_o), (k == n) ? 128'd1 : 128'd0);
    end
    chk({tag, " R5 idle"}, 128'(sbox_use_o), 128'd0);
  endtask

  task automatic cmp_all(input int n, input string tag);
    logic [127:0] v;
    for (int r = 0; r < n; r++) begin
      read_rk(r, v);
      chk(tag, v, ref_rk(r));
    end
  endtask

  task automatic test_reset;
    chk("R1 ready", 128'(ready_o), 128'd0);
    chk("R1 use", 128'(sbox_use_o), 128'd0);
  endtask

  task automatic test_aes128;
    logic [127:0] v;
    build_ref(K128, 1'b0);
    start(K128, 1'b0);
    wait_done(11, "t128");
    cmp_all(11, "R2 schedule");
    read_rk(1, v);  chk("R2 rk1", v, 128'ha0fafe1788542cb123a339392a6c7605);
    read_rk(10, v); chk("R2 rk10", v, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);
    read_rk(0, v);  chk("R8 rk0", v, K128[255:128]);
  endtask

  task automatic test_aes256;
    logic [127:0] v;
    build_ref(K256, 1'b1);
    start(K256, 1'b1);
    wait_done(15, "t256");
    cmp_all(15, "R3 schedule");
    read_rk(1, v);  chk("R3 rk1", v, K256[127:0]);
    read_rk(2, v);  chk("R3 rk2", v, 128'h9ba354118e6925afa51a8b5f2067fcde);
    read_rk(14, v); chk("R8 R3 rk14", v, 128'hfe4890d1e6188d0b046df344706c631e);
  endtask

  task automatic test_low_half_ignored;
    logic [127:0] v;
    start({K128[255:128], 128'hdeadbeef_0badf00d_55aa55aa_12345678}, 1'b0);
    wait_done(11, "r4_");
    read_rk(10, v); chk("R4 rk10", v, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);
    read_rk(5, v);
    build_ref(K128, 1'b0);
    chk("R4 rk5", v, ref_rk(5));
  endtask

  task automatic test_input_change;
    build_ref(K256, 1'b1);
    start(K256, 1'b1);
    @(negedge clk);
    key_i = ~K256; key_len_i = 1'b0;
    wait_done(14, "r7_");
    cmp_all(15, "R7 schedule");
  endtask

  task automatic test_restart;
    start(K256, 1'b1);
    repeat (4) @(negedge clk);
    build_ref(K128, 1'b0);
    start(K128, 1'b0);
    wait_done(11, "r9_");
    cmp_all(11, "R9 schedule");
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset;
    test_aes128;
    test_aes256;
    test_low_half_ignored;
    test_input_change;
    test_restart;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule